// File: doc/BRIEF.md
# Oversampling Serial Receive Controller

This block takes an asynchronous serial line and turns each frame into a parallel byte. A sample-rate strobe runs at eight pulses per bit. The controller acts only on clock cycles where that strobe is high.

When the idle line falls low, the controller counts strobes into the start bit. It keeps the start bit only if the line is still low at the start bit's midpoint. It then samples each later bit at its own midpoint, eight strobes after the previous sample. The eight data bits arrive least significant bit first and shift into a receive register toward the LSB. The ninth sample is the stop bit.

At the stop sample the controller hands the byte to a data register for the host and reports two separate error conditions:
- The host was still busy, so the new word was dropped.
- The stop bit was not high.

Baud-rate generation, parity and the host bus are handled elsewhere.

Top module: `uart_rx_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rx_data_out` is 0, and `byte_ready_out`, `overrun_err_out` and `frame_err_out` are all 0.
- R2: The controller changes state only on cycles with `tick_in` high. While the line stays high, no frame is received and no output changes.
- R3: A start bit is accepted only if `serial_in` is low on five consecutive strobes. A high level on any of the four strobes after the first low one returns the controller to idle. A low pulse lasting four strobes or fewer produces no byte, no pulse and no flag change.
- R4: After start acceptance, each bit is sampled every 8 strobes. The eight data bits are taken least significant bit first, so the first data bit lands in `rx_data_out[0]`.
- R5: At the stop-bit sample, if `host_busy_in` is low, `rx_data_out` takes the received byte. In the same cycle `byte_ready_out` goes high for exactly one clock. `rx_data_out` changes at no other time.
- R6: If `host_busy_in` is high at the stop-bit sample, `overrun_err_out` is set. In that case `rx_data_out` keeps its previous value and `byte_ready_out` does not pulse.
- R7: If the stop-bit sample is 0, `frame_err_out` is set. If the host is ready, the byte is still loaded and `byte_ready_out` still pulses.
- R8: Both error flags are rewritten at every stop-bit sample and cleared there when their condition is absent. Between stop-bit samples they hold their value, including across rejected glitches.
- R9: After the stop-bit sample the controller is idle at once. A start bit that immediately follows a stop bit, with no idle gap, is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Sample strobe, 8 per bit time |
| serial_in | input | 1 | Serial receive line, idle high |
| host_busy_in | input | 1 | High while the host cannot accept a byte |
| rx_data_out | output | 8 | Last byte delivered to the host |
| byte_ready_out | output | 1 | One-clock pulse when `rx_data_out` loads |
| overrun_err_out | output | 1 | Last frame ended while the host was busy |
| frame_err_out | output | 1 | Last frame had a low stop bit |

## Verification
Every result of a frame appears one clock after the strobe edge that samples the stop bit. That edge is strobe 76 counted from the first strobe that sees the line low. The byte, the pulse and both flags all settle in the middle of the stop-bit window, and then hold.

The bench drives each bit for exactly eight strobes starting just after a strobe edge, and checks only after the stop window has closed. It counts `byte_ready_out` pulses with a falling-edge monitor, so a pulse of any length is seen. Rejected glitches are judged at the ports a full bit time after the line returns high, by confirming that the byte, the pulse count and both flags are unchanged.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_RECV  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/uart_rx_counters.sv
module uart_rx_counters #(
  parameter int DATA_BITS = 8,
  parameter int SMP_W     = 3,
  parameter int BIT_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_smp,
  input  logic             inc_smp,
  input  logic             clr_bit,
  input  logic             inc_bit,
  output logic [SMP_W-1:0] smp_cnt,
  output logic [BIT_W-1:0] bit_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_cnt <= '0;
    end else if (clr_smp) begin
      smp_cnt <= '0;
    end else if (inc_smp) begin
      smp_cnt <= smp_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
    end else if (clr_bit) begin
      bit_cnt <= '0;
    end else if (inc_bit) begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // R4: data bits plus the stop slot never push the bit count past the frame
  p_bitcnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= BIT_W'(DATA_BITS));
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 8,
  parameter int DATA_BITS  = 8,
  parameter int SMP_W      = 3,
  parameter int BIT_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic             serial_in,
  input  logic [SMP_W-1:0] smp_cnt,
  input  logic [BIT_W-1:0] bit_cnt,
  output logic             clr_smp,
  output logic             inc_smp,
  output logic             clr_bit,
  output logic             inc_bit,
  output logic             shift_en,
  output logic             load_en
);
  localparam int MID_CNT  = OVERSAMPLE / 2 - 1;
  localparam int LAST_CNT = OVERSAMPLE - 1;

  rx_state_e state, nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    nxt      = state;
    clr_smp  = 1'b0;
    inc_smp  = 1'b0;
    clr_bit  = 1'b0;
    inc_bit  = 1'b0;
    shift_en = 1'b0;
    load_en  = 1'b0;
    if (tick_in) begin
      case (state)
        ST_IDLE: begin
          if (!serial_in) begin
            nxt     = ST_START;
            clr_smp = 1'b1;
          end
        end
        ST_START: begin
          if (serial_in) begin
            nxt = ST_IDLE;
          end else if (smp_cnt == SMP_W'(MID_CNT)) begin
            nxt     = ST_RECV;
            clr_smp = 1'b1;
            clr_bit = 1'b1;
          end else begin
            inc_smp = 1'b1;
          end
        end
        ST_RECV: begin
          if (smp_cnt == SMP_W'(LAST_CNT)) begin
            clr_smp = 1'b1;
            if (bit_cnt == BIT_W'(DATA_BITS)) begin
              load_en = 1'b1;
              nxt     = ST_IDLE;
            end else begin
              shift_en = 1'b1;
              inc_bit  = 1'b1;
            end
          end else begin
            inc_smp = 1'b1;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  // R2: no state change without a strobe
  p_tick_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !tick_in |=> state == $past(state));
  // R2: a high line keeps the idle controller idle
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && tick_in && serial_in) |=> state == ST_IDLE);
  // R3: a high sample during start qualification aborts to idle
  p_glitch_abort_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && tick_in && serial_in) |=> state == ST_IDLE);
  // R9: the stop sample returns the controller to idle
  p_stop_to_idle_r9: assert property (@(posedge clk) disable iff (rst)
    load_en |=> state == ST_IDLE);
endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 serial_in,
  input  logic                 host_busy_in,
  input  logic                 shift_en,
  input  logic                 load_en,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 byte_ready,
  output logic                 overrun_err,
  output logic                 frame_err
);
  logic [DATA_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg       <= '0;
      rx_data     <= '0;
      byte_ready  <= 1'b0;
      overrun_err <= 1'b0;
      frame_err   <= 1'b0;
    end else begin
      byte_ready <= 1'b0;
      if (shift_en) shreg <= {serial_in, shreg[DATA_BITS-1:1]};
      if (load_en) begin
        overrun_err <= host_busy_in;
        frame_err   <= ~serial_in;
        if (!host_busy_in) begin
          rx_data    <= shreg;
          byte_ready <= 1'b1;
        end
      end
    end
  end

  // R5: the ready pulse lasts one clock
  p_pulse_width_r5: assert property (@(posedge clk) disable iff (rst)
    byte_ready |=> !byte_ready);
  // R5: the data register changes only together with the ready pulse
  p_data_only_on_load_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_data != $past(rx_data)) |-> byte_ready);
  // R6: an overrun frame never delivers a byte
  p_overrun_no_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    byte_ready |-> !overrun_err);
  // R8: flags hold between stop samples
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> ($stable(frame_err) && $stable(overrun_err)));
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl #(
  parameter int OVERSAMPLE = 8,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_in,
  input  logic                 serial_in,
  input  logic                 host_busy_in,
  output logic [DATA_BITS-1:0] rx_data_out,
  output logic                 byte_ready_out,
  output logic                 overrun_err_out,
  output logic                 frame_err_out
);
  localparam int SMP_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int BIT_W = $clog2(DATA_BITS + 1);

  logic [SMP_W-1:0] smp_cnt;
  logic [BIT_W-1:0] bit_cnt;
  logic clr_smp, inc_smp, clr_bit, inc_bit, shift_en, load_en;

  uart_rx_fsm #(
    .OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS), .SMP_W(SMP_W), .BIT_W(BIT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .tick_in(tick_in), .serial_in(serial_in),
    .smp_cnt(smp_cnt), .bit_cnt(bit_cnt),
    .clr_smp(clr_smp), .inc_smp(inc_smp), .clr_bit(clr_bit), .inc_bit(inc_bit),
    .shift_en(shift_en), .load_en(load_en)
  );

  uart_rx_counters #(
    .DATA_BITS(DATA_BITS), .SMP_W(SMP_W), .BIT_W(BIT_W)
  ) u_cnt (
    .clk(clk), .rst(rst),
    .clr_smp(clr_smp), .inc_smp(inc_smp), .clr_bit(clr_bit), .inc_bit(inc_bit),
    .smp_cnt(smp_cnt), .bit_cnt(bit_cnt)
  );

  uart_rx_datapath #(
    .DATA_BITS(DATA_BITS)
  ) u_dp (
    .clk(clk), .rst(rst), .serial_in(serial_in), .host_busy_in(host_busy_in),
    .shift_en(shift_en), .load_en(load_en),
    .rx_data(rx_data_out), .byte_ready(byte_ready_out),
    .overrun_err(overrun_err_out), .frame_err(frame_err_out)
  );
endmodule

// File: tb/tb_uart_rx_ctrl.sv
module tb_uart_rx_ctrl;
  localparam int OS  = 8;
  localparam int DB  = 8;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic ser = 1'b1;
  logic busy = 1'b0;
  logic [DB-1:0] rx_data;
  logic byte_ready, overrun_err, frame_err;

  int n_vec = 0;
  int n_bad = 0;
  int divc = 0;
  int pulses = 0;
  logic done = 1'b0;
  logic [DB-1:0] last_data = '0;
  logic last_ov = 1'b0;
  logic last_fe = 1'b0;

  uart_rx_ctrl #(.OVERSAMPLE(OS), .DATA_BITS(DB)) dut (
    .clk(clk), .rst(rst), .tick_in(tick), .serial_in(ser), .host_busy_in(busy),
    .rx_data_out(rx_data), .byte_ready_out(byte_ready),
    .overrun_err_out(overrun_err), .frame_err_out(frame_err)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tick = (divc == DIV - 1);
    divc = (divc == DIV - 1) ? 0 : divc + 1;
    if (!rst && byte_ready) pulses++;
  end

  function automatic logic [DB-1:0] exp_data(logic [DB-1:0] prev, logic [DB-1:0] d, logic b);
    return b ? prev : d;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (tick !== 1'b1) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic drive_bit(logic b);
    ser = b;
    wait_ticks(OS);
  endtask

  task automatic send_frame(logic [DB-1:0] d, logic stop_ok, logic b);
    busy = b;
    drive_bit(1'b0);
    for (int i = 0; i < DB; i++) drive_bit(d[i]);
    drive_bit(stop_ok);
    ser = 1'b1;
  endtask

  task automatic frame_check(string tag, logic [DB-1:0] d, logic stop_ok, logic b);
    int p0;
    p0 = pulses;
    send_frame(d, stop_ok, b);
    wait_ticks(3);
    busy = 1'b0;
    last_data = exp_data(last_data, d, b);
    last_ov = b;
    last_fe = !stop_ok;
    chk({tag, " R4/R5/R6 data"}, 32'(rx_data), 32'(last_data));
    chk({tag, " R5/R6 pulses"}, 32'(pulses - p0), b ? 32'd0 : 32'd1);
    chk({tag, " R6 overrun"}, 32'(overrun_err), 32'(b));
    chk({tag, " R7 frame"}, 32'(frame_err), 32'(!stop_ok));
    wait_ticks(OS + 2);
  endtask

  task automatic glitch_check(int n);
    int p0;
    p0 = pulses;
    ser = 1'b0;
    wait_ticks(n);
    ser = 1'b1;
    wait_ticks(OS + 4);
    chk("R3 glitch data", 32'(rx_data), 32'(last_data));
    chk("R3 glitch pulses", 32'(pulses - p0), 32'd0);
    chk("R8 glitch flags", {30'd0, overrun_err, frame_err}, {30'd0, last_ov, last_fe});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DB-1:0] d;
    logic b, s, g;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1: reset values while reset is held
    chk("R1 reset", {20'd0, rx_data, byte_ready, overrun_err, frame_err, 1'b0}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {20'd0, rx_data, byte_ready, overrun_err, frame_err, 1'b0}, 32'd0);
    // R2: line held high for several bit times
    wait_ticks(3 * OS);
    chk("R2 idle line", 32'(pulses), 32'd0);
    chk("R2 idle data", 32'(rx_data), 32'd0);
    // R4: LSB-first ordering and pattern variety
    frame_check("a5", 8'hA5, 1'b1, 1'b0);
    frame_check("01", 8'h01, 1'b1, 1'b0);
    frame_check("80", 8'h80, 1'b1, 1'b0);
    frame_check("00", 8'h00, 1'b1, 1'b0);
    frame_check("ff", 8'hFF, 1'b1, 1'b0);
    // R6: busy host keeps the old byte
    frame_check("busy", 8'h3C, 1'b1, 1'b1);
    // R7: low stop bit still delivers
    frame_check("badstop", 8'h5A, 1'b0, 1'b0);
    frame_check("both", 8'hC3, 1'b0, 1'b1);
    // R8: a clean frame clears both flags
    frame_check("clean", 8'h96, 1'b1, 1'b0);
    // R3: longest rejected glitch and shortest one
    glitch_check(4);
    glitch_check(1);
    // R9: back-to-back frames with no idle gap
    begin
      int p0;
      p0 = pulses;
      send_frame(8'h12, 1'b1, 1'b0);
      send_frame(8'hE7, 1'b1, 1'b0);
      wait_ticks(3);
      last_data = 8'hE7; last_ov = 1'b0; last_fe = 1'b0;
      chk("R9 b2b data", 32'(rx_data), 32'hE7);
      chk("R9 b2b pulses", 32'(pulses - p0), 32'd2);
      wait_ticks(OS);
    end
    // random mix
    for (int k = 0; k < 24; k++) begin
      d = 8'($urandom);
      b = ($urandom % 4) == 0;
      s = ($urandom % 7) != 0;
      g = ($urandom % 5) == 0;
      if (g) glitch_check(1 + int'($urandom % 4));
      frame_check("rand", d, s, b);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule